// File: doc/BRIEF.md
# Reduction-Engine Register File

This block is the register file of a micro-sequenced processor that evaluates programs by rewriting an expression in memory. It holds three 8-bit index counters: the source index, the destination index and the function index. It also holds a save register for the destination index, an 8-bit value register, a 4-bit argument counter, a 4-bit state register, and a 4-bit class register. The class register keeps the class of the current symbol and a flag that shows whether the argument counter has reached its logical zero.

Every register changes only when the micro-sequencer asserts one of its strobes. The strobes are synchronous enables, sampled on the rising edge of `clk`. A 2-bit select picks the memory address. The address comes from the source index, the destination index, the function index, or the external ALU result, which carries the source index plus an argument offset during argument binding. The argument counter counts upward and uses all-ones as its logical zero, so its zero flag is simply its terminal count. Before a function reduction that has to be postponed, the destination index is saved. It is then restored later so that writing resumes at the saved target position.

Top module: `redux_regfile`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register clears to zero. After that edge `addr`, `state`, `scz`, `v_out`, `si_out` and `ac_out` read 0 and `ac_zero` reads 0.
- R2: The destination index has this priority: `di_clr` clears it, else `di_ld` loads `data_in`, else `di_restore` loads the save register, else `di_inc` adds 1. The increment wraps from 8'hFF to 8'h00.
- R3: `ri_save` copies the destination index as it stood before the edge into the save register. If `ri_save` and `di_restore` are asserted in the same cycle, the destination index receives the previous saved value.
- R4: `si_clr` clears the source index and takes priority over `si_inc`. `fi_ld` loads `data_in` into the function index and takes priority over `fi_inc`. Both counters wrap modulo 256.
- R5: `ac_ld` loads `data_in[3:0]` into the argument counter and takes priority over `ac_inc`. The counter wraps from 4'hF to 4'h0. `ac_zero` is 1 exactly when the counter holds 4'b1111.
- R6: The value register has this priority: `v_clr` clears it, else `v_ld_data` loads `data_in`, else `v_ld_alu` loads `alu_res`.
- R7: The state register loads `st_next` only on a cycle with `st_ld`. Otherwise it holds its value.
- R8: `scz_ld` loads `scz` with `ac_zero` (as it stood before the edge) in bit 3 and `sym_class` in bits 2..0. Otherwise `scz` holds its value.
- R9: `addr` is combinational from `addr_sel`: 0 gives the source index, 1 the destination index, 2 the function index, and 3 `alu_res`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 8 | Data word from memory |
| sym_class | input | 3 | Class of the current symbol |
| alu_res | input | 8 | ALU result (SI plus offset when binding) |
| di_clr | input | 1 | Clear destination index |
| di_ld | input | 1 | Load destination index from data_in |
| di_restore | input | 1 | Load destination index from save register |
| di_inc | input | 1 | Increment destination index |
| ri_save | input | 1 | Copy destination index into save register |
| si_clr | input | 1 | Clear source index |
| si_inc | input | 1 | Increment source index |
| fi_ld | input | 1 | Load function index from data_in |
| fi_inc | input | 1 | Increment function index |
| ac_ld | input | 1 | Load argument counter from data_in[3:0] |
| ac_inc | input | 1 | Increment argument counter |
| v_clr | input | 1 | Clear value register |
| v_ld_data | input | 1 | Load value register from data_in |
| v_ld_alu | input | 1 | Load value register from alu_res |
| st_ld | input | 1 | Load state register |
| st_next | input | 4 | Next state value |
| scz_ld | input | 1 | Load class/zero register |
| addr_sel | input | 2 | Address source select |
| addr | output | 8 | Memory address |
| state | output | 4 | Current state register |
| scz | output | 4 | Zero flag and symbol class |
| v_out | output | 8 | Value register, to the ALU |
| si_out | output | 8 | Source index, to the ALU |
| ac_out | output | 4 | Argument counter, to the ALU |
| ac_zero | output | 1 | Argument counter at logical zero |

## Verification
Each register result is due at the first rising edge after its strobe is applied. `addr` and `ac_zero` follow their register without any further delay, and `addr` also follows `addr_sel` combinationally. The driver applies strobes at the falling edge and queues the expected contents after the rising edge that consumes them. The monitor samples every output 2 ns after that rising edge, well before the next input change, so each queued item is compared against the cycle it describes. Simultaneous strobes, counter wraps, and a save combined with a restore in the same cycle are each driven as separate stimuli.

// File: rtl/redux_regfile_pkg.sv
// Shared types for the reduction-engine register file.
package redux_regfile_pkg;

    // Address source encoding; the numeric values are decoded by the sequencer.
    typedef enum logic [1:0] {
        ASEL_SRC  = 2'd0,
        ASEL_DST  = 2'd1,
        ASEL_FUN  = 2'd2,
        ASEL_BIND = 2'd3
    } asel_e;

endpackage

// File: rtl/rf_counter.sv
// Generic up-counter with a synchronous clear, load and increment.
// Priority: clear, then load, then increment. Reset is synchronous and active low.
// Assumes the strobes are stable around the rising edge of clk.
module rf_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    // Counter state update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + ONE;
    end
endmodule

// File: rtl/rf_reg.sv
// Plain register with a synchronous clear and load; clear wins over load.
// Reset is synchronous and active low.
module rf_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Storage update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (ld)  q <= d;
    end
endmodule

// File: rtl/rf_addr_mux.sv
// Four-way address selector. It is purely combinational; the select values
// follow redux_regfile_pkg::asel_e.
module rf_addr_mux
    import redux_regfile_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] src_idx,
    input  logic [W-1:0] dst_idx,
    input  logic [W-1:0] fun_idx,
    input  logic [W-1:0] bind_addr,
    output logic [W-1:0] addr
);
    // Choose the address source.
    always_comb begin
        unique case (asel_e'(sel))
            ASEL_SRC:  addr = src_idx;
            ASEL_DST:  addr = dst_idx;
            ASEL_FUN:  addr = fun_idx;
            default:   addr = bind_addr;
        endcase
    end
endmodule

// File: rtl/redux_regfile.sv
// Register file of a micro-sequenced expression-reduction processor.
// It holds the index counters, the destination save register, the value
// register, the argument counter (all-ones means logical zero), the state
// register and the class/zero register, and it selects the memory address.
// Assumes: a single rising-edge clock, synchronous strobes and a synchronous
// active-low reset.
module redux_regfile #(
    parameter int IDX_W = 8,
    parameter int AC_W  = 4,
    parameter int ST_W  = 4,
    parameter int CLS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] data_in,
    input  logic [CLS_W-1:0] sym_class,
    input  logic [IDX_W-1:0] alu_res,
    input  logic             di_clr,
    input  logic             di_ld,
    input  logic             di_restore,
    input  logic             di_inc,
    input  logic             ri_save,
    input  logic             si_clr,
    input  logic             si_inc,
    input  logic             fi_ld,
    input  logic             fi_inc,
    input  logic             ac_ld,
    input  logic             ac_inc,
    input  logic             v_clr,
    input  logic             v_ld_data,
    input  logic             v_ld_alu,
    input  logic             st_ld,
    input  logic [ST_W-1:0]  st_next,
    input  logic             scz_ld,
    input  logic [1:0]       addr_sel,
    output logic [IDX_W-1:0] addr,
    output logic [ST_W-1:0]  state,
    output logic [CLS_W:0]   scz,
    output logic [IDX_W-1:0] v_out,
    output logic [IDX_W-1:0] si_out,
    output logic [AC_W-1:0]  ac_out,
    output logic             ac_zero
);
    localparam int SCZ_W = CLS_W + 1;

    logic [IDX_W-1:0] di_q, ri_q, fi_q, di_src, v_src;
    logic [SCZ_W-1:0] scz_d;

    // Destination load source: memory data wins over the saved index.
    always_comb di_src = di_ld ? data_in : ri_q;

    // Value load source: memory data wins over the ALU result.
    always_comb v_src = v_ld_data ? data_in : alu_res;

    // Logical zero of the argument counter is its terminal count.
    always_comb ac_zero = &ac_out;

    // Class/zero register input: flag on top, class below.
    always_comb scz_d = {ac_zero, sym_class};

    rf_counter #(.W(IDX_W)) u_di (
        .clk(clk), .rst_n(rst_n), .clr(di_clr), .ld(di_ld | di_restore),
        .ld_val(di_src), .inc(di_inc), .q(di_q));

    rf_counter #(.W(IDX_W)) u_si (
        .clk(clk), .rst_n(rst_n), .clr(si_clr), .ld(1'b0),
        .ld_val('0), .inc(si_inc), .q(si_out));

    rf_counter #(.W(IDX_W)) u_fi (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(fi_ld),
        .ld_val(data_in), .inc(fi_inc), .q(fi_q));

    rf_counter #(.W(AC_W)) u_ac (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(ac_ld),
        .ld_val(data_in[AC_W-1:0]), .inc(ac_inc), .q(ac_out));

    rf_reg #(.W(IDX_W)) u_ri (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(ri_save),
        .d(di_q), .q(ri_q));

    rf_reg #(.W(IDX_W)) u_v (
        .clk(clk), .rst_n(rst_n), .clr(v_clr), .ld(v_ld_data | v_ld_alu),
        .d(v_src), .q(v_out));

    rf_reg #(.W(ST_W)) u_st (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(st_ld),
        .d(st_next), .q(state));

    rf_reg #(.W(SCZ_W)) u_scz (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(scz_ld),
        .d(scz_d), .q(scz));

    rf_addr_mux #(.W(IDX_W)) u_mux (
        .sel(addr_sel), .src_idx(si_out), .dst_idx(di_q), .fun_idx(fi_q),
        .bind_addr(alu_res), .addr(addr));
endmodule

// File: rtl/redux_regfile_chk.sv
// Property checker for redux_regfile, attached to it by the bind below.
module redux_regfile_chk #(
    parameter int IDX_W = 8,
    parameter int AC_W  = 4,
    parameter int ST_W  = 4,
    parameter int CLS_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             di_clr,
    input logic             di_ld,
    input logic             di_restore,
    input logic             si_clr,
    input logic             v_clr,
    input logic             st_ld,
    input logic             scz_ld,
    input logic [CLS_W-1:0] sym_class,
    input logic [IDX_W-1:0] di_q,
    input logic [IDX_W-1:0] ri_q,
    input logic [IDX_W-1:0] si_out,
    input logic [IDX_W-1:0] v_out,
    input logic [ST_W-1:0]  state,
    input logic [CLS_W:0]   scz,
    input logic [AC_W-1:0]  ac_out,
    input logic             ac_zero
);
    // R2: a clear empties the destination index.
    a_r2_di_clear: assert property (@(posedge clk) disable iff (!rst_n)
        di_clr |=> di_q == '0);
    // R3: a restore with no higher-priority strobe brings back the saved index.
    a_r3_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (di_restore && !di_clr && !di_ld) |=> di_q == $past(ri_q));
    // R4: the source-index clear wins.
    a_r4_si_clear: assert property (@(posedge clk) disable iff (!rst_n)
        si_clr |=> si_out == '0);
    // R5: the zero flag follows the all-ones counter value.
    a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ac_zero == (ac_out == {AC_W{1'b1}}));
    // R6: the value clear wins.
    a_r6_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
        v_clr |=> v_out == '0);
    // R7: the state holds without a load.
    a_r7_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ld |=> $stable(state));
    // R8: the class/zero register captures the flag and the class.
    a_r8_scz_load: assert property (@(posedge clk) disable iff (!rst_n)
        scz_ld |=> scz == {$past(ac_zero), $past(sym_class)});
    // R8: the class/zero register holds without a load.
    a_r8_scz_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !scz_ld |=> $stable(scz));
endmodule

bind redux_regfile redux_regfile_chk #(
    .IDX_W(IDX_W), .AC_W(AC_W), .ST_W(ST_W), .CLS_W(CLS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .di_clr(di_clr), .di_ld(di_ld),
    .di_restore(di_restore), .si_clr(si_clr), .v_clr(v_clr), .st_ld(st_ld),
    .scz_ld(scz_ld), .sym_class(sym_class), .di_q(di_q), .ri_q(ri_q),
    .si_out(si_out), .v_out(v_out), .state(state), .scz(scz),
    .ac_out(ac_out), .ac_zero(ac_zero));

// File: tb/redux_regfile_tb_top.sv
// Scoreboard bench: the driver queues expected outputs, the monitor compares them.
module redux_regfile_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    logic [7:0] data_in, alu_res;
    logic [2:0] sym_class;
    logic di_clr, di_ld, di_restore, di_inc, ri_save, si_clr, si_inc;
    logic fi_ld, fi_inc, ac_ld, ac_inc, v_clr, v_ld_data, v_ld_alu;
    logic st_ld, scz_ld;
    logic [3:0] st_next;
    logic [1:0] addr_sel;
    logic [7:0] addr, v_out, si_out;
    logic [3:0] state, scz, ac_out;
    logic ac_zero;

    always #4 clk = ~clk; // 125 MHz

    redux_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .sym_class(sym_class),
        .alu_res(alu_res), .di_clr(di_clr), .di_ld(di_ld),
        .di_restore(di_restore), .di_inc(di_inc), .ri_save(ri_save),
        .si_clr(si_clr), .si_inc(si_inc), .fi_ld(fi_ld), .fi_inc(fi_inc),
        .ac_ld(ac_ld), .ac_inc(ac_inc), .v_clr(v_clr), .v_ld_data(v_ld_data),
        .v_ld_alu(v_ld_alu), .st_ld(st_ld), .st_next(st_next),
        .scz_ld(scz_ld), .addr_sel(addr_sel), .addr(addr), .state(state),
        .scz(scz), .v_out(v_out), .si_out(si_out), .ac_out(ac_out),
        .ac_zero(ac_zero));

    typedef struct {
        string      req;
        logic [7:0] addr, v, si;
        logic [3:0] st, scz, ac;
        logic       z;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [7:0] m_di = 0, m_ri = 0, m_si = 0, m_fi = 0, m_v = 0;
    logic [3:0] m_ac = 0, m_st = 0, m_scz = 0;

    // Drop every strobe.
    task automatic idle();
        {di_clr, di_ld, di_restore, di_inc, ri_save, si_clr, si_inc} = '0;
        {fi_ld, fi_inc, ac_ld, ac_inc, v_clr, v_ld_data, v_ld_alu} = '0;
        {st_ld, scz_ld} = '0;
    endtask

    // Driver: consume one edge, update the model from the requirements, queue it.
    task automatic tick(input string req);
        exp_t e;
        logic [7:0] n_di, n_ri, n_si, n_fi, n_v;
        logic [3:0] n_ac, n_st, n_scz;
        @(posedge clk);
        if (!rst_n) begin
            {n_di, n_ri, n_si, n_fi, n_v} = '0;
            {n_ac, n_st, n_scz} = '0;
        end else begin
            n_di = di_clr ? 8'h00 : di_ld ? data_in : di_restore ? m_ri
                 : di_inc ? m_di + 8'd1 : m_di;
            n_ri = ri_save ? m_di : m_ri;
            n_si = si_clr ? 8'h00 : si_inc ? m_si + 8'd1 : m_si;
            n_fi = fi_ld ? data_in : fi_inc ? m_fi + 8'd1 : m_fi;
            n_ac = ac_ld ? data_in[3:0] : ac_inc ? m_ac + 4'd1 : m_ac;
            n_v  = v_clr ? 8'h00 : v_ld_data ? data_in : v_ld_alu ? alu_res : m_v;
            n_st = st_ld ? st_next : m_st;
            n_scz = scz_ld ? {m_ac == 4'hF, sym_class} : m_scz;
        end
        {m_di, m_ri, m_si, m_fi, m_v} = {n_di, n_ri, n_si, n_fi, n_v};
        {m_ac, m_st, m_scz} = {n_ac, n_st, n_scz};
        e.req = req;
        case (addr_sel)
            2'd0: e.addr = m_si;
            2'd1: e.addr = m_di;
            2'd2: e.addr = m_fi;
            default: e.addr = alu_res;
        endcase
        e.v = m_v; e.si = m_si; e.st = m_st; e.scz = m_scz;
        e.ac = m_ac; e.z = (m_ac == 4'hF);
        q.push_back(e);
        @(negedge clk);
        idle();
    endtask

    // Monitor: compare 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if ({addr, v_out, si_out, state, scz, ac_out, ac_zero} !==
                    {e.addr, e.v, e.si, e.st, e.scz, e.ac, e.z}) begin
                    n_bad++;
                    $display("FAIL %s: addr=%h v=%h si=%h st=%h scz=%h ac=%h z=%b expected addr=%h v=%h si=%h st=%h scz=%h ac=%h z=%b",
                        e.req, addr, v_out, si_out, state, scz, ac_out, ac_zero,
                        e.addr, e.v, e.si, e.st, e.scz, e.ac, e.z);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        idle();
        rst_n = 1'b0; data_in = 8'h00; alu_res = 8'h00; sym_class = 3'd0;
        st_next = 4'd0; addr_sel = 2'd0;
        @(negedge clk);
        tick("R1 reset");
        rst_n = 1'b1;
        tick("R1 idle after reset");
        // R2 destination index.
        addr_sel = 2'd1; data_in = 8'h40; di_ld = 1; tick("R2 load");
        di_inc = 1; tick("R2 inc");
        data_in = 8'h77; di_clr = 1; di_ld = 1; di_inc = 1; tick("R2 clear wins");
        data_in = 8'h21; di_ld = 1; di_restore = 1; di_inc = 1; tick("R2 load wins");
        data_in = 8'hFF; di_ld = 1; tick("R2 load FF");
        di_inc = 1; tick("R2 wrap");
        // R3 save and restore.
        data_in = 8'h55; di_ld = 1; tick("R3 setup");
        ri_save = 1; tick("R3 save");
        di_inc = 1; tick("R3 move away");
        di_inc = 1; tick("R3 move away");
        di_restore = 1; di_inc = 1; tick("R3 restore over inc");
        data_in = 8'h10; di_ld = 1; tick("R3 setup 2");
        ri_save = 1; di_restore = 1; tick("R3 save+restore same cycle");
        di_restore = 1; tick("R3 restore new save");
        // R4 source and function index.
        addr_sel = 2'd0; si_inc = 1; tick("R4 si inc");
        si_inc = 1; tick("R4 si inc");
        si_clr = 1; si_inc = 1; tick("R4 si clear wins");
        addr_sel = 2'd2; data_in = 8'hFE; fi_ld = 1; fi_inc = 1; tick("R4 fi load wins");
        fi_inc = 1; tick("R4 fi inc");
        fi_inc = 1; tick("R4 fi wrap");
        // R5 argument counter.
        data_in = 8'hAE; ac_ld = 1; ac_inc = 1; tick("R5 load wins");
        ac_inc = 1; tick("R5 reach logical zero");
        ac_inc = 1; tick("R5 wrap");
        data_in = 8'h0F; ac_ld = 1; tick("R5 load zero code");
        // R8 class/zero register, with the counter at logical zero.
        sym_class = 3'd5; scz_ld = 1; tick("R8 load with flag");
        sym_class = 3'd2; tick("R8 hold");
        ac_inc = 1; tick("R8 setup");
        sym_class = 3'd6; scz_ld = 1; tick("R8 load without flag");
        // R6 value register.
        data_in = 8'h3C; alu_res = 8'h81; v_ld_data = 1; v_ld_alu = 1; tick("R6 data wins");
        v_ld_alu = 1; tick("R6 alu load");
        v_clr = 1; v_ld_data = 1; tick("R6 clear wins");
        // R7 state register.
        st_next = 4'hA; st_ld = 1; tick("R7 load");
        st_next = 4'h3; tick("R7 hold");
        st_next = 4'hF; st_ld = 1; tick("R7 final state");
        // R9 address select.
        addr_sel = 2'd3; alu_res = 8'h9D; tick("R9 bind source");
        addr_sel = 2'd0; tick("R9 source index");
        addr_sel = 2'd1; tick("R9 destination index");
        addr_sel = 2'd2; tick("R9 function index");
        // R1 reset mid-run.
        rst_n = 1'b0; tick("R1 reset again");
        rst_n = 1'b1;
        @(posedge clk); #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule